// File: doc/BRIEF.md
# Stereo Serial Audio Capture Receiver

This block is the receive side of a serial audio port. It watches three serial lines: the bit clock, the word-select (frame) line and the data line. All three are treated as ordinary inputs in the system clock domain. The bit clock may come from a local clock generator or from an external codec. Every frame carries a left slot and a right slot, and both are always stored. From each slot the block keeps the leading most-significant bits: 8 or 16 of them. It sign-extends the sample to 16 bits and pushes it, tagged with its channel, into a receive FIFO.

Software or a DMA engine reads the FIFO through a valid/ready stream port. The back-pressure rules are as follows:
- `rd_valid` stays high whenever the FIFO holds data.
- `rd_data` and `rd_right` hold steady until a cycle where both `rd_valid` and `rd_ready` are high. That cycle removes the head entry.
- The serial side cannot be stalled. A sample that finds the FIFO full is discarded and sets the sticky overrun flag.

A service request stays asserted while the FIFO holds more entries than a programmable threshold.

Top module: `aud_serial_rx`

## Requirements
- R1: After reset the FIFO is empty: `rd_valid`=0, `level`=0, `svc_req`=0, `ovr_flag`=0 and `ovr_irq`=0.
- R2: Framing and channel order:
  - `lrclk`=0 marks the left slot and `lrclk`=1 marks the right slot. Each slot lasts 32 bit-clock periods.
  - Data is sampled on rising `bclk` edges, most significant bit first.
  - Samples enter the FIFO in arrival order. `rd_right` is 0 for a left sample and 1 for a right sample.
- R3: With `fmt_msb`=0 (I2S timing), the first data bit is sampled on the second rising edge of the slot. The bit on the first edge is ignored.
- R4: With `fmt_msb`=1 (MSB-justified timing), the first data bit is sampled on the first rising edge of the slot.
- R5: Sample size:
  - `size_code`=0 keeps 8 bits per slot and sign-extends them to 16 bits on `rd_data`.
  - Any other code keeps 16 bits.
  - Bits later in the slot have no effect.
- R6: Samples are captured only while `en_global` and `en_capture` are both 1. After enabling, capture begins with the first slot whose `lrclk` change is seen while enabled. While disabled, nothing is written to the FIFO.
- R7: Read port behaviour:
  - `rd_valid`=1 whenever `level`>0.
  - The head entry leaves on a cycle where `rd_valid` and `rd_ready` are both 1.
  - While `rd_ready`=0, `rd_data` and `rd_right` do not change.
- R8: `svc_req` is 1 exactly while `level` is greater than `thresh`. The usual programmed value of `thresh` is 7.
- R9: A sample completed while the FIFO holds `DEPTH` entries at the start of that cycle is dropped, and `ovr_flag` is set on the next cycle.
- R10: `ovr_flag` stays set until a one-cycle `ovr_clr` pulse clears it. A new overrun in the same cycle wins over the clear. `ovr_irq` equals `ovr_flag` AND `ovr_irq_en`.
- R11: A `flush` pulse empties the FIFO on the next cycle. It overrides any read or sample arrival in the same cycle, and such a sample does not set `ovr_flag`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| en_global | input | 1 | Port-wide enable |
| en_capture | input | 1 | Capture-path enable |
| fmt_msb | input | 1 | 0: I2S one-bit delay, 1: MSB-justified |
| size_code | input | 3 | 0: 8-bit samples, others: 16-bit |
| thresh | input | 4 | Service-request threshold |
| flush | input | 1 | Empty the FIFO |
| ovr_clr | input | 1 | Write-one-to-clear pulse for the overrun flag |
| ovr_irq_en | input | 1 | Overrun interrupt enable |
| bclk | input | 1 | Serial bit clock |
| lrclk | input | 1 | Word-select line, 0 = left slot |
| sdin | input | 1 | Serial data |
| rd_data | output | 16 | Head sample, sign-extended |
| rd_right | output | 1 | Head sample channel, 1 = right |
| rd_valid | output | 1 | FIFO holds at least one sample |
| rd_ready | input | 1 | Reader accepts the head sample |
| level | output | 5 | FIFO fill level |
| svc_req | output | 1 | Fill level above threshold |
| ovr_flag | output | 1 | Sticky overrun status |
| ovr_irq | output | 1 | Overrun interrupt |

## Verification
The bench builds the block with its defaults: a 16-entry FIFO, 16-bit samples and 32-bit slots. With these values, the 4-bit threshold of 7 can be crossed after four frames. Nine frames fill the FIFO and push it into overrun within a few thousand cycles. Both slot timings, both sample sizes, disabled capture, stalls on the read port, flush and the clearing of overrun are all reached in one short run.

// File: rtl/aud_rx_pkg.sv
package aud_rx_pkg;
  typedef enum logic {
    FMT_I2S  = 1'b0,
    FMT_LEFT = 1'b1
  } rx_fmt_e;

  localparam int RX_SAMPLE_W = 16;
  localparam int RX_SLOT_BITS = 32;
endpackage

// File: rtl/aud_rx_deser.sv
module aud_rx_deser #(
  parameter int SAMPLE_W  = aud_rx_pkg::RX_SAMPLE_W,
  parameter int SLOT_BITS = aud_rx_pkg::RX_SLOT_BITS
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                run,
  input  logic                fmt_msb,
  input  logic                wide,
  input  logic                bclk,
  input  logic                lrclk,
  input  logic                sdin,
  output logic                push,
  output logic                push_right,
  output logic [SAMPLE_W-1:0] push_data
);
  import aud_rx_pkg::*;
  localparam int CW   = $clog2(SLOT_BITS) + 1;
  localparam int HALF = SAMPLE_W / 2;

  logic                bclk_q, lr_q, synced;
  logic [CW-1:0]       cnt, pos, idx, nbits;
  logic [SAMPLE_W-1:0] shreg, assembled;
  logic                rise, flip, idx_ok, live, take;
  rx_fmt_e             fmt;

  assign fmt  = rx_fmt_e'(fmt_msb);
  assign rise = bclk & ~bclk_q;
  assign flip = lrclk ^ lr_q;

  // slot position of the current edge and bit index it carries
  always_comb begin
    pos    = flip ? '0 : cnt;
    idx_ok = (fmt == FMT_LEFT) ? 1'b1 : (pos != '0);
    idx    = (fmt == FMT_LEFT) ? pos : pos - 1'b1;
    nbits  = wide ? CW'(SAMPLE_W) : CW'(HALF);
    live   = synced | (flip & run);
    take   = rise & run & live & idx_ok & (idx < nbits);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bclk_q <= 1'b0;
      lr_q   <= 1'b0;
      cnt    <= '0;
      synced <= 1'b0;
      shreg  <= '0;
    end else begin
      bclk_q <= bclk;
      if (rise) begin
        lr_q <= lrclk;
        if (flip)                    cnt <= CW'(1);
        else if (cnt != CW'(SLOT_BITS)) cnt <= cnt + 1'b1;
      end
      if (!run)              synced <= 1'b0;
      else if (rise && flip) synced <= 1'b1;
      if (take) shreg <= {shreg[SAMPLE_W-2:0], sdin};
    end
  end

  assign assembled  = {shreg[SAMPLE_W-2:0], sdin};
  assign push       = take & (idx == nbits - 1'b1);
  assign push_right = lrclk;
  assign push_data  = wide ? assembled
                           : {{(SAMPLE_W-HALF){assembled[HALF-1]}}, assembled[HALF-1:0]};

  AST_PUSH_ISOLATED: assert property (@(posedge clk) disable iff (!rst_n)
    push |=> !push) else $error("two pushes on adjacent cycles"); // R2
endmodule

// File: rtl/aud_rx_fifo.sv
module aud_rx_fifo #(
  parameter int W     = 17,
  parameter int DEPTH = 16,
  localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int LW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          wr_en,
  input  logic [W-1:0]  wr_data,
  input  logic          rd_ready,
  output logic          rd_valid,
  output logic [W-1:0]  rd_data,
  output logic [LW-1:0] level,
  output logic          full
);
  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wp, rp;
  logic          do_wr, do_rd;

  assign full     = (level == LW'(DEPTH));
  assign rd_valid = (level != '0);
  assign rd_data  = mem[rp];
  assign do_wr    = wr_en & ~full & ~flush;
  assign do_rd    = rd_valid & rd_ready & ~flush;

  always_ff @(posedge clk) begin
    if (do_wr) mem[wp] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      wp    <= '0;
      rp    <= '0;
      level <= '0;
    end else begin
      if (do_wr) wp <= (wp == PW'(DEPTH-1)) ? '0 : wp + 1'b1;
      if (do_rd) rp <= (rp == PW'(DEPTH-1)) ? '0 : rp + 1'b1;
      case ({do_wr, do_rd})
        2'b10:   level <= level + 1'b1;
        2'b01:   level <= level - 1'b1;
        default: level <= level;
      endcase
    end
  end

  AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> level == '0) else $error("flush left entries"); // R11
  AST_HEAD_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid && !rd_ready && !flush |=> rd_valid && $stable(rd_data)) else $error("head moved"); // R7
  AST_LEVEL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    full |=> level <= LW'(DEPTH)) else $error("level beyond depth"); // R9
endmodule

// File: rtl/aud_serial_rx.sv
module aud_serial_rx #(
  parameter int SAMPLE_W  = aud_rx_pkg::RX_SAMPLE_W,
  parameter int SLOT_BITS = aud_rx_pkg::RX_SLOT_BITS,
  parameter int DEPTH     = 16,
  parameter int THR_W     = 4,
  localparam int LW       = $clog2(DEPTH + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                en_global,
  input  logic                en_capture,
  input  logic                fmt_msb,
  input  logic [2:0]          size_code,
  input  logic [THR_W-1:0]    thresh,
  input  logic                flush,
  input  logic                ovr_clr,
  input  logic                ovr_irq_en,
  input  logic                bclk,
  input  logic                lrclk,
  input  logic                sdin,
  output logic [SAMPLE_W-1:0] rd_data,
  output logic                rd_right,
  output logic                rd_valid,
  input  logic                rd_ready,
  output logic [LW-1:0]       level,
  output logic                svc_req,
  output logic                ovr_flag,
  output logic                ovr_irq
);
  logic                run, wide, push, push_right, full, ovr_evt;
  logic [SAMPLE_W-1:0] push_data;
  logic [SAMPLE_W:0]   head;

  assign run  = en_global & en_capture;
  assign wide = (size_code != 3'd0);

  aud_rx_deser #(.SAMPLE_W(SAMPLE_W), .SLOT_BITS(SLOT_BITS)) u_deser (
    .clk(clk), .rst_n(rst_n), .run(run), .fmt_msb(fmt_msb), .wide(wide),
    .bclk(bclk), .lrclk(lrclk), .sdin(sdin),
    .push(push), .push_right(push_right), .push_data(push_data)
  );

  aud_rx_fifo #(.W(SAMPLE_W + 1), .DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n), .flush(flush), .wr_en(push),
    .wr_data({push_right, push_data}), .rd_ready(rd_ready),
    .rd_valid(rd_valid), .rd_data(head), .level(level), .full(full)
  );

  assign rd_right = head[SAMPLE_W];
  assign rd_data  = head[SAMPLE_W-1:0];
  assign svc_req  = 32'(level) > 32'(thresh);
  assign ovr_evt  = push & full & ~flush;

  always_ff @(posedge clk) begin
    if (!rst_n)       ovr_flag <= 1'b0;
    else if (ovr_evt) ovr_flag <= 1'b1;
    else if (ovr_clr) ovr_flag <= 1'b0;
  end

  assign ovr_irq = ovr_flag & ovr_irq_en;

  AST_OVR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    ovr_flag && !ovr_clr |=> ovr_flag) else $error("overrun flag lost"); // R10
  AST_OVR_RAISED: assert property (@(posedge clk) disable iff (!rst_n)
    push && full && !flush |=> ovr_flag) else $error("overrun not flagged"); // R9
  AST_IDLE_STILL: assert property (@(posedge clk) disable iff (!rst_n)
    !run && !rd_ready && !flush |=> $stable(level)) else $error("fifo moved while idle"); // R6
endmodule

// File: tb/aud_serial_rx_test.sv
module aud_serial_rx_test;
  localparam int DEPTH = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en_global = 0, en_capture = 0, fmt_msb = 0, flush = 0, ovr_clr = 0, ovr_irq_en = 0;
  logic [2:0] size_code = 3'd1;
  logic [3:0] thresh = 4'd7;
  logic bclk = 0, lrclk = 0, sdin = 0, rd_ready = 0;
  logic [15:0] rd_data;
  logic rd_right, rd_valid, svc_req, ovr_flag, ovr_irq;
  logic [4:0] level;

  always #2 clk = ~clk;

  aud_serial_rx uut (
    .clk(clk), .rst_n(rst_n), .en_global(en_global), .en_capture(en_capture),
    .fmt_msb(fmt_msb), .size_code(size_code), .thresh(thresh), .flush(flush),
    .ovr_clr(ovr_clr), .ovr_irq_en(ovr_irq_en), .bclk(bclk), .lrclk(lrclk),
    .sdin(sdin), .rd_data(rd_data), .rd_right(rd_right), .rd_valid(rd_valid),
    .rd_ready(rd_ready), .level(level), .svc_req(svc_req), .ovr_flag(ovr_flag),
    .ovr_irq(ovr_irq)
  );

  int checks = 0;
  int fails = 0;
  bit cmp_on = 0;
  bit [16:0] q[$];
  bit m_ovr = 0;
  bit pend = 0;
  bit [16:0] pend_val;
  bit b_sync = 0;
  bit b_lr = 0;
  int cyc = 0;

  task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h t=%0t", tag, what, act, exp, $time);
    end
  endtask

  // behavioural reference, one step per clock
  always @(posedge clk) begin
    if (!rst_n) begin
      q.delete(); m_ovr = 0; pend = 0;
    end else begin
      automatic bit was_full = (q.size() == DEPTH);
      if (flush) begin
        q.delete(); pend = 0;
        if (ovr_clr) m_ovr = 0;
      end else begin
        automatic bit set_ovr = 0;
        if (q.size() > 0 && rd_ready) void'(q.pop_front());
        if (pend) begin
          if (was_full) set_ovr = 1; else q.push_back(pend_val);
          pend = 0;
        end
        if (set_ovr) m_ovr = 1; else if (ovr_clr) m_ovr = 0;
      end
    end
  end

  always @(posedge clk) begin
    #1;
    cyc++;
    if (cmp_on && rst_n) begin
      chk(rd_valid == (q.size() > 0), "R7", "rd_valid", rd_valid, q.size() > 0);
      chk(level == q.size(), "R2", "level", level, q.size());
      if (q.size() > 0) begin
        chk(rd_data == q[0][15:0], "R2", "rd_data", rd_data, q[0][15:0]);
        chk(rd_right == q[0][16], "R2", "rd_right", rd_right, q[0][16]);
      end
      chk(svc_req == (q.size() > thresh), "R8", "svc_req", svc_req, q.size() > thresh);
      chk(ovr_flag == m_ovr, "R9", "ovr_flag", ovr_flag, m_ovr);
      chk(ovr_irq == (m_ovr && ovr_irq_en), "R10", "ovr_irq", ovr_irq, m_ovr && ovr_irq_en);
    end
  end

  // watchdog
  initial begin
    #400000;
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  task automatic drive_bit(input bit lr, input bit b, input bit fin, input bit [16:0] v);
    @(negedge clk); bclk = 0; lrclk = lr; sdin = b;
    @(negedge clk);
    @(negedge clk); bclk = 1;
    if (fin) begin pend = 1; pend_val = v; end
    @(negedge clk);
  endtask

  task automatic send_slot(input bit lr, input bit [15:0] val);
    automatic int nb = (size_code == 0) ? 8 : 16;
    automatic bit [15:0] ext = (nb == 8) ? {{8{val[7]}}, val[7:0]} : val;
    if (!(en_global && en_capture)) b_sync = 0;
    else if (lr != b_lr) b_sync = 1;
    b_lr = lr;
    for (int p = 0; p < 32; p++) begin
      automatic int ix = fmt_msb ? p : p - 1;
      automatic bit b = (p % 3 == 0);
      automatic bit fin = 0;
      if (ix >= 0 && ix < nb) begin
        b = val[nb-1-ix];
        fin = b_sync && (ix == nb - 1);
      end
      drive_bit(lr, b, fin, {lr, ext});
    end
  endtask

  task automatic wait_empty();
    for (int i = 0; i < 200 && level != 0; i++) @(negedge clk);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    chk(rd_valid == 0 && level == 0, "R1", "empty after reset", level, 0);
    chk(svc_req == 0 && ovr_flag == 0 && ovr_irq == 0, "R1", "flags after reset", {svc_req, ovr_flag, ovr_irq}, 0);
    rst_n = 1;
    cmp_on = 1;
    @(negedge clk);

    // I2S, 16-bit
    en_global = 1; en_capture = 1; fmt_msb = 0; size_code = 3'd1;
    send_slot(1, 16'h1234);
    for (int k = 0; k < 5; k++) begin
      send_slot(0, 16'hA5C3 + 16'(k));
      send_slot(1, 16'h8001 + 16'(k * 3));
    end
    chk(rd_data == 16'h1234 && rd_right == 1, "R3", "i2s first sample", rd_data, 16'h1234);
    chk(level == 11 && svc_req == 1, "R8", "above threshold", level, 11);

    // drain with stalls
    for (int i = 0; i < 40; i++) begin
      @(negedge clk); rd_ready = (i % 3 != 1);
    end
    @(negedge clk); rd_ready = 0;
    chk(level == 0 && rd_valid == 0, "R7", "drained", level, 0);

    // MSB-justified, 8-bit
    fmt_msb = 1; size_code = 3'd0;
    send_slot(0, 16'h009A);
    send_slot(1, 16'h0035);
    chk(rd_data == 16'hFF9A && rd_right == 0, "R5", "8-bit sign extend left", rd_data, 16'hFF9A);
    @(negedge clk); rd_ready = 1;
    @(negedge clk); rd_ready = 0;
    chk(rd_data == 16'h0035 && rd_right == 1, "R4", "msb-justified right", rd_data, 16'h0035);
    rd_ready = 1; wait_empty(); rd_ready = 0;

    // disabled capture
    en_capture = 0;
    send_slot(0, 16'h0011);
    send_slot(1, 16'h0022);
    chk(level == 0, "R6", "capture disabled", level, 0);
    en_capture = 1; en_global = 0;
    send_slot(0, 16'h0033);
    chk(level == 0, "R6", "global disabled", level, 0);
    en_global = 1;

    // overrun
    size_code = 3'd1;
    for (int k = 0; k < 10; k++) begin
      send_slot(1, 16'h7000 + 16'(k));
      send_slot(0, 16'h0F00 + 16'(k));
    end
    chk(level == DEPTH && ovr_flag == 1, "R9", "overrun flagged", {level, ovr_flag}, {5'(DEPTH), 1'b1});
    chk(rd_data == 16'h7000, "R9", "oldest kept", rd_data, 16'h7000);
    ovr_irq_en = 1;
    @(negedge clk);
    chk(ovr_irq == 1, "R10", "irq raised", ovr_irq, 1);
    ovr_clr = 1; @(negedge clk); ovr_clr = 0;
    chk(ovr_flag == 0 && ovr_irq == 0, "R10", "cleared", ovr_flag, 0);

    // flush
    flush = 1; @(negedge clk); flush = 0;
    chk(level == 0 && rd_valid == 0, "R11", "flush empties", level, 0);
    send_slot(1, 16'h4321);
    chk(level == 1 && rd_data == 16'h4321, "R11", "capture after flush", rd_data, 16'h4321);

    repeat (4) @(negedge clk);
    cmp_on = 0;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule